// File: doc/BRIEF.md
# Two-Way Set-Associative Write-Back Cache Controller

This block sits between a processor-side word port and a memory port that moves whole blocks. Each request carries a byte address. The address is cut into three fields: a word offset inside a 16-byte block, a set index and a tag. The index picks a set of two lines. Both stored tags are compared with the request tag at the same time, and the word of the matching line is passed out through a multiplexer.

On a miss, the controller picks a victim line. An empty line in the set is used first. If both lines are full, it takes the line that was not used most recently, which one bit per set tracks. A modified victim is written to memory as a whole block. The missing block is then read and installed, and the request is looked up again so that it hits. Writes change only the cached line and mark it modified. Memory sees the change only when that line is evicted.

The processor holds `req_valid` while the controller is idle. The controller raises `busy` while it works on the request. It then gives a one-cycle `rsp_valid` with the result.

Top module: `assoc2_cache`

## Requirements
- R1: After an active-low synchronous reset, `busy`, `rsp_valid` and `mem_valid` are low and every line is invalid and unmodified. The first access to any address misses, and a line modified before the reset is dropped without a block write.
- R2: A read hit gives the stored word on `rsp_rdata` with `rsp_valid` high two clock edges after the accepting edge, and it causes no memory request.
- R3: Address bits [3:2] select the word in the block, bits [9:4] select one of 64 sets, and bits [31:10] form the tag. Two blocks with the same index and different tags can be held at once.
- R4: A miss on a clean victim issues exactly one block read at the block-aligned address (low four bits zero). It answers with the backing data five edges after acceptance when memory accepts at once and returns data one edge later.
- R5: When a set has an empty line, a miss fills that line and evicts nothing.
- R6: One bit per set names the replacement line. A hit or a fill on a line makes the other line the next victim.
- R7: A write hit stores the word in the line and marks the line modified, with no memory request. `rsp_rdata` returns the written word.
- R8: Evicting a modified line first issues one block write (`mem_write`=1) of the whole modified block at its old block address, and then the block read. With immediate memory the response comes six edges after acceptance.
- R9: Evicting an unmodified line issues no block write.
- R10: A write miss fetches the block, merges the written word and leaves the line modified. The other words of the block keep their memory values.
- R11: `busy` is high on every cycle from the accepting edge until the response, and `rsp_valid` lasts exactly one cycle.
- R12: A memory request keeps `mem_valid`, `mem_write`, `mem_addr` and `mem_wdata` stable until `mem_ready`. Every `mem_ready` wait cycle adds one cycle to the miss latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; accepted while the controller is idle |
| req_write | input | 1 | 1 = word write, 0 = word read |
| req_addr | input | 32 | Byte address of the word |
| req_wdata | input | 32 | Write data |
| busy | output | 1 | Request in progress, processor must stall |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_rdata | output | 32 | Read word, or the written word for writes |
| mem_valid | output | 1 | Block request to memory |
| mem_write | output | 1 | 1 = block write-back, 0 = block read |
| mem_addr | output | 32 | Block-aligned byte address |
| mem_wdata | output | 128 | Block being written back |
| mem_ready | input | 1 | Memory accepts the request this cycle |
| mem_rvalid | input | 1 | Read block returned this cycle |
| mem_rdata | input | 128 | Returned block |

## Verification
Each result has a fixed cycle count, measured in clock edges from the edge that accepts the request. A hit answers after 2 edges. A fill into a clean or empty line answers after 5 edges plus one for each memory wait cycle. A modified eviction answers after 6 edges plus the wait cycles of both of its memory requests.

The bench computes that count for every access from the set contents it expects and the wait setting of its memory model. It counts edges until `rsp_valid` appears and samples the data on the falling edge in that same cycle. It also checks the number of block reads and writes, the write-back address and block, and that `busy` stays high through every earlier sampled cycle.

// File: rtl/a2c_pkg.sv
// Shared types for the two-way cache controller.
// Assumes: one request is in flight at a time.
package a2c_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_COMPARE,
        ST_WRITEBACK,
        ST_REFILL,
        ST_RESPOND
    } a2c_state_e;
endpackage

// File: rtl/a2c_tag_array.sv
// Per-set tag, valid, modified and replacement state for both ways.
// Assumes: fill and touch are never requested in the same cycle.
module a2c_tag_array #(
    parameter int SETS  = 64,
    parameter int TAG_W = 22,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [IDX_W-1:0]       set_i,
    output logic [1:0][TAG_W-1:0]  tag_o,
    output logic [1:0]             valid_o,
    output logic [1:0]             dirty_o,
    output logic                   lru_o,
    input  logic                   fill_en_i,
    input  logic                   fill_way_i,
    input  logic [TAG_W-1:0]       fill_tag_i,
    input  logic                   touch_en_i,
    input  logic                   touch_way_i,
    input  logic                   touch_dirty_i
);
    logic [1:0]       valid_q [SETS];
    logic [1:0]       dirty_q [SETS];
    logic [SETS-1:0]  lru_q;
    logic [TAG_W-1:0] tag_q   [SETS][2];

    // Status bits: cleared by reset, updated by fills and touches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                dirty_q[s] <= '0;
            end
            lru_q <= '0;
        end else begin
            if (fill_en_i) begin
                valid_q[set_i][fill_way_i] <= 1'b1;
                dirty_q[set_i][fill_way_i] <= 1'b0;
                lru_q[set_i]               <= ~fill_way_i;
            end else if (touch_en_i) begin
                lru_q[set_i] <= ~touch_way_i;
                if (touch_dirty_i) begin
                    dirty_q[set_i][touch_way_i] <= 1'b1;
                end
            end
        end
    end

    // Tag storage: written on fill only, needs no reset.
    always_ff @(posedge clk) begin
        if (fill_en_i) begin
            tag_q[set_i][fill_way_i] <= fill_tag_i;
        end
    end

    generate
        for (genvar w = 0; w < 2; w++) begin : g_rd
            assign tag_o[w]   = tag_q[set_i][w];
            assign valid_o[w] = valid_q[set_i][w];
            assign dirty_o[w] = dirty_q[set_i][w];

            // R7
            dirty_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
                dirty_o[w] |-> valid_o[w]);
        end
    endgenerate

    assign lru_o = lru_q[set_i];

    // R6
    touch_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en_i |-> valid_o[touch_way_i]);
endmodule

// File: rtl/a2c_way_match.sv
// Parallel tag compare of both ways, plus victim selection.
// Assumes: tags and valid bits come from the addressed set.
module a2c_way_match #(
    parameter int TAG_W = 22
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0][TAG_W-1:0] tag_i,
    input  logic [1:0]            valid_i,
    input  logic                  lru_i,
    input  logic [TAG_W-1:0]      req_tag_i,
    output logic                  hit_o,
    output logic                  hit_way_o,
    output logic                  victim_way_o
);
    logic [1:0] match;

    generate
        for (genvar w = 0; w < 2; w++) begin : g_cmp
            assign match[w] = valid_i[w] && (tag_i[w] == req_tag_i);
        end
    endgenerate

    assign hit_o     = |match;
    assign hit_way_o = match[1];

    // Victim pick: an empty way first, otherwise the replacement bit.
    always_comb begin
        if (!valid_i[0])      victim_way_o = 1'b0;
        else if (!valid_i[1]) victim_way_o = 1'b1;
        else                  victim_way_o = lru_i;
    end

    // R3
    single_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R5
    empty_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i[0] || !valid_i[1]) |-> !valid_i[victim_way_o]);
endmodule

// File: rtl/a2c_data_array.sv
// Block storage for both ways; full-block fill and single-word write.
// Assumes: fill and word write never target the same cycle.
module a2c_data_array #(
    parameter int SETS   = 64,
    parameter int WORD_W = 32,
    parameter int WORDS  = 4,
    localparam int IDX_W = $clog2(SETS),
    localparam int WO_W  = $clog2(WORDS),
    localparam int BLK_W = WORD_W * WORDS
) (
    input  logic                  clk,
    input  logic [IDX_W-1:0]      set_i,
    output logic [1:0][BLK_W-1:0] blk_o,
    input  logic                  fill_en_i,
    input  logic                  fill_way_i,
    input  logic [BLK_W-1:0]      fill_blk_i,
    input  logic                  word_en_i,
    input  logic                  word_way_i,
    input  logic [WO_W-1:0]       word_idx_i,
    input  logic [WORD_W-1:0]     word_i
);
    logic [BLK_W-1:0] blk_q [SETS][2];

    generate
        for (genvar k = 0; k < WORDS; k++) begin : g_word
            // Word lane k: loaded by a fill or by a matching word write.
            always_ff @(posedge clk) begin
                if (fill_en_i) begin
                    blk_q[set_i][fill_way_i][k*WORD_W +: WORD_W] <= fill_blk_i[k*WORD_W +: WORD_W];
                end else if (word_en_i && (word_idx_i == WO_W'(k))) begin
                    blk_q[set_i][word_way_i][k*WORD_W +: WORD_W] <= word_i;
                end
            end
        end
        for (genvar w = 0; w < 2; w++) begin : g_rd
            assign blk_o[w] = blk_q[set_i][w];
        end
    endgenerate
endmodule

// File: rtl/a2c_ctrl.sv
// Request sequencer: lookup, optional write-back, refill, response.
// Assumes: memory returns read data only after accepting a read.
module a2c_ctrl
    import a2c_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_valid_i,
    input  logic hit_i,
    input  logic victim_way_i,
    input  logic victim_valid_i,
    input  logic victim_dirty_i,
    input  logic mem_ready_i,
    input  logic mem_rvalid_i,
    output logic accept_o,
    output logic touch_en_o,
    output logic fill_en_o,
    output logic vic_way_o,
    output logic busy_o,
    output logic rsp_valid_o,
    output logic mem_valid_o,
    output logic mem_write_o
);
    a2c_state_e state_q, state_d;
    logic       rd_sent_q;
    logic       vic_way_q;

    // Next-state decision for the request sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (req_valid_i) state_d = ST_COMPARE;
            ST_COMPARE:   if (hit_i) state_d = ST_RESPOND;
                          else if (victim_valid_i && victim_dirty_i) state_d = ST_WRITEBACK;
                          else state_d = ST_REFILL;
            ST_WRITEBACK: if (mem_ready_i) state_d = ST_REFILL;
            ST_REFILL:    if (rd_sent_q && mem_rvalid_i) state_d = ST_COMPARE;
            ST_RESPOND:   state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State, read-issued flag and latched victim way.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rd_sent_q <= 1'b0;
            vic_way_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_COMPARE && !hit_i) vic_way_q <= victim_way_i;
            if (state_q == ST_REFILL) begin
                if (!rd_sent_q && mem_ready_i) rd_sent_q <= 1'b1;
                else if (rd_sent_q && mem_rvalid_i) rd_sent_q <= 1'b0;
            end
        end
    end

    assign accept_o    = (state_q == ST_IDLE) && req_valid_i;
    assign touch_en_o  = (state_q == ST_COMPARE) && hit_i;
    assign fill_en_o   = (state_q == ST_REFILL) && rd_sent_q && mem_rvalid_i;
    assign vic_way_o   = vic_way_q;
    assign busy_o      = (state_q == ST_COMPARE) || (state_q == ST_WRITEBACK) || (state_q == ST_REFILL);
    assign rsp_valid_o = (state_q == ST_RESPOND);
    assign mem_write_o = (state_q == ST_WRITEBACK);
    assign mem_valid_o = mem_write_o || ((state_q == ST_REFILL) && !rd_sent_q);

    // R11
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid_o |=> !rsp_valid_o);

    // R11
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |=> busy_o);

    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_write_o)));
endmodule

// File: rtl/assoc2_cache.sv
// Two-way set-associative write-back cache with one replacement bit per set.
// Assumes: one outstanding request; requests are accepted only when idle.
module assoc2_cache #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int WORDS  = 4,
    parameter int SETS   = 64,
    localparam int BYTE_OFF = $clog2(WORD_W / 8),
    localparam int WO_W     = $clog2(WORDS),
    localparam int IDX_W    = $clog2(SETS),
    localparam int BLK_OFF  = BYTE_OFF + WO_W,
    localparam int TAG_W    = ADDR_W - BLK_OFF - IDX_W,
    localparam int BLK_W    = WORD_W * WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              busy,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_rdata,
    output logic              mem_valid,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [BLK_W-1:0]  mem_wdata,
    input  logic              mem_ready,
    input  logic              mem_rvalid,
    input  logic [BLK_W-1:0]  mem_rdata
);
    logic              rq_write_q;
    logic [ADDR_W-1:0] rq_addr_q;
    logic [WORD_W-1:0] rq_wdata_q;
    logic [WORD_W-1:0] rdata_q;

    logic [WO_W-1:0]  word_idx;
    logic [IDX_W-1:0] set_idx;
    logic [TAG_W-1:0] req_tag;

    logic [1:0][TAG_W-1:0] tags;
    logic [1:0]            valids, dirtys;
    logic                  lru;
    logic [1:0][BLK_W-1:0] blks;
    logic hit, hit_way, victim_way, vic_way;
    logic accept, touch_en, fill_en;

    assign word_idx = rq_addr_q[BYTE_OFF +: WO_W];
    assign set_idx  = rq_addr_q[BLK_OFF +: IDX_W];
    assign req_tag  = rq_addr_q[ADDR_W-1 -: TAG_W];

    // Request capture on acceptance; held through the whole sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_write_q <= 1'b0;
            rq_addr_q  <= '0;
            rq_wdata_q <= '0;
        end else if (accept) begin
            rq_write_q <= req_write;
            rq_addr_q  <= req_addr;
            rq_wdata_q <= req_wdata;
        end
    end

    // Response word: written word for writes, selected way's word for reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (touch_en) begin
            rdata_q <= rq_write_q ? rq_wdata_q : blks[hit_way][word_idx*WORD_W +: WORD_W];
        end
    end

    a2c_tag_array #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
        .clk(clk), .rst_n(rst_n), .set_i(set_idx),
        .tag_o(tags), .valid_o(valids), .dirty_o(dirtys), .lru_o(lru),
        .fill_en_i(fill_en), .fill_way_i(vic_way), .fill_tag_i(req_tag),
        .touch_en_i(touch_en), .touch_way_i(hit_way), .touch_dirty_i(rq_write_q)
    );

    a2c_way_match #(.TAG_W(TAG_W)) u_match (
        .clk(clk), .rst_n(rst_n), .tag_i(tags), .valid_i(valids), .lru_i(lru),
        .req_tag_i(req_tag), .hit_o(hit), .hit_way_o(hit_way), .victim_way_o(victim_way)
    );

    a2c_data_array #(.SETS(SETS), .WORD_W(WORD_W), .WORDS(WORDS)) u_data (
        .clk(clk), .set_i(set_idx), .blk_o(blks),
        .fill_en_i(fill_en), .fill_way_i(vic_way), .fill_blk_i(mem_rdata),
        .word_en_i(touch_en && rq_write_q), .word_way_i(hit_way),
        .word_idx_i(word_idx), .word_i(rq_wdata_q)
    );

    a2c_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid_i(req_valid), .hit_i(hit),
        .victim_way_i(victim_way), .victim_valid_i(valids[victim_way]),
        .victim_dirty_i(dirtys[victim_way]), .mem_ready_i(mem_ready),
        .mem_rvalid_i(mem_rvalid), .accept_o(accept), .touch_en_o(touch_en),
        .fill_en_o(fill_en), .vic_way_o(vic_way), .busy_o(busy),
        .rsp_valid_o(rsp_valid), .mem_valid_o(mem_valid), .mem_write_o(mem_write)
    );

    assign rsp_rdata = rdata_q;
    assign mem_wdata = blks[vic_way];
    assign mem_addr  = mem_write ? {tags[vic_way], set_idx, {BLK_OFF{1'b0}}}
                                 : {req_tag, set_idx, {BLK_OFF{1'b0}}};

    // R8
    wb_only_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && mem_write) |-> (valids[vic_way] && dirtys[vic_way]));

    // R12
    mem_payload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_wdata)));

    // R2
    hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        touch_en |-> !mem_valid);
endmodule

// File: tb/test_assoc2_cache.sv
module test_assoc2_cache;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0, req_write = 1'b0;
    logic [31:0]  req_addr = '0, req_wdata = '0;
    logic         busy, rsp_valid, mem_valid, mem_write, mem_ready;
    logic [31:0]  rsp_rdata, mem_addr;
    logic [127:0] mem_wdata, mem_rdata;
    logic         mem_rvalid;

    int n_chk = 0, n_bad = 0;
    int rd_cnt = 0, wr_cnt = 0;
    int stall_cfg = 0, wait_q = 0;
    logic [31:0] bk_mem  [1024];
    logic [31:0] ref_mem [1024];
    logic [31:0] wb_addr;
    logic [127:0] wb_blk;

    always #5 clk = ~clk;

    assoc2_cache i_assoc2_cache (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .mem_valid(mem_valid), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // Backing memory: ready after stall_cfg wait cycles, read data one edge after acceptance.
    assign mem_ready = (wait_q >= stall_cfg);
    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (mem_valid && !mem_ready) wait_q <= wait_q + 1;
        else wait_q <= 0;
        if (mem_valid && mem_ready) begin
            if (mem_write) begin
                wr_cnt  <= wr_cnt + 1;
                wb_addr <= mem_addr;
                wb_blk  <= mem_wdata;
                for (int k = 0; k < 4; k++)
                    bk_mem[{mem_addr[11:4], 2'(k)}] <= mem_wdata[k*32 +: 32];
            end else begin
                rd_cnt     <= rd_cnt + 1;
                mem_rvalid <= 1'b1;
                for (int k = 0; k < 4; k++)
                    mem_rdata[k*32 +: 32] <= bk_mem[{mem_addr[11:4], 2'(k)}];
            end
        end
    end

    function automatic logic [31:0] mk_addr(int t, int s, int w);
        return 32'((t << 10) | (s << 4) | (w << 2));
    endfunction

    function automatic int mk_idx(int t, int s, int w);
        return t * 256 + s * 4 + w;
    endfunction

    task automatic chk(string rq, string what, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    // One access: checks latency, data, memory traffic and busy.
    task automatic acc(bit wr, int t, int s, int w, logic [31:0] wd,
                       int elat, int erd, int ewr, string rq);
        int lat = 0;
        int rd0, wr0;
        bit busy_ok = 1'b1;
        logic [31:0] exp;
        @(negedge clk);
        rd0 = rd_cnt; wr0 = wr_cnt;
        req_valid = 1'b1; req_write = wr; req_addr = mk_addr(t, s, w); req_wdata = wd;
        if (wr) ref_mem[mk_idx(t, s, w)] = wd;
        exp = ref_mem[mk_idx(t, s, w)];
        do begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            req_valid = 1'b0;
            if (!rsp_valid && !busy) busy_ok = 1'b0;
        end while (!rsp_valid && lat < 100);
        chk(rq, "latency", 128'(lat), 128'(elat));
        chk(rq, "data", 128'(rsp_rdata), 128'(exp));
        chk(rq, "block reads", 128'(rd_cnt - rd0), 128'(erd));
        chk(rq, "block writes", 128'(wr_cnt - wr0), 128'(ewr));
        // R11: busy high until the response, low with it
        chk("R11", "busy", {busy_ok, busy}, {1'b1, 1'b0});
    endtask

    task automatic chk_wb(int t, int s, string rq);
        logic [127:0] e;
        for (int k = 0; k < 4; k++) e[k*32 +: 32] = ref_mem[mk_idx(t, s, k)];
        chk(rq, "writeback addr", 128'(wb_addr), 128'(mk_addr(t, s, 0)));
        chk(rq, "writeback block", wb_blk, e);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: outputs idle during and after reset
        chk("R1", "reset outputs", {busy, rsp_valid, mem_valid}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "post-reset outputs", {busy, rsp_valid, mem_valid}, 3'b000);
        for (int i = 0; i < 1024; i++) ref_mem[i] = bk_mem[i];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 1024; i++) begin
            bk_mem[i]  = 32'(i) * 32'h0100_0193 + 32'h5A5A_0000;
            ref_mem[i] = bk_mem[i];
        end
        do_reset();

        // Phase A: R3 R4 R5 R2 - fill both ways of every set, then hit both
        for (int s = 0; s < 64; s++) begin
            acc(0, 0, s, s % 4, 0, 5, 1, 0, "R4");
            acc(0, 1, s, (s + 1) % 4, 0, 5, 1, 0, "R5");
            acc(0, 0, s, s % 4, 0, 2, 0, 0, "R3");
            acc(0, 1, s, (s + 2) % 4, 0, 2, 0, 0, "R2");
        end

        // Phase B: R7 R6 R9 R8 - write hit, replacement order, dirty eviction
        for (int s = 0; s < 64; s++) begin
            acc(1, 1, s, s % 4, 32'hC0DE_0000 + 32'(s), 2, 0, 0, "R7");
            acc(0, 2, s, s % 4, 0, 5, 1, 0, "R9");
            acc(0, 1, s, s % 4, 0, 2, 0, 0, "R6");
            acc(0, 3, s, s % 4, 0, 5, 1, 0, "R6");
            acc(0, 0, s, s % 4, 0, 6, 1, 1, "R8");
            chk_wb(1, s, "R8");
            acc(0, 1, s, s % 4, 0, 5, 1, 0, "R8");
        end

        // Phase C: R10 - write miss allocates and merges
        for (int s = 0; s < 64; s++) begin
            acc(1, 2, s, (s + 2) % 4, 32'hBEEF_0000 + 32'(s), 5, 1, 0, "R10");
            acc(0, 2, s, (s + 2) % 4, 0, 2, 0, 0, "R10");
            acc(0, 2, s, ((s + 2) % 4) ^ 1, 0, 2, 0, 0, "R10");
            acc(0, 0, s, 0, 0, 5, 1, 0, "R9");
            acc(0, 3, s, 1, 0, 6, 1, 1, "R10");
            chk_wb(2, s, "R10");
        end

        // Phase D: R12 - memory wait cycles stretch the miss latency
        for (int s = 0; s < 12; s++) begin
            stall_cfg = s % 3;
            acc(1, 3, s, 3, 32'hFACE_0000 + 32'(s), 2, 0, 0, "R12");
            acc(0, 1, s, 2, 0, 5 + stall_cfg, 1, 0, "R12");
            acc(0, 2, s, 0, 0, 6 + 2 * stall_cfg, 1, 1, "R12");
            chk_wb(3, s, "R12");
            acc(0, 3, s, 3, 0, 5 + stall_cfg, 1, 0, "R12");
        end
        stall_cfg = 0;

        // Phase E: R1 - reset drops lines and modified state
        do_reset();
        acc(0, 0, 40, 1, 0, 5, 1, 0, "R1");
        acc(1, 0, 40, 1, 32'h1234_5678, 2, 0, 0, "R7");
        do_reset();
        acc(0, 0, 40, 1, 0, 5, 1, 0, "R1");
        acc(0, 1, 40, 1, 0, 5, 1, 0, "R5");
        acc(0, 2, 40, 1, 0, 5, 1, 0, "R1");

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule